// File: doc/BRIEF.md
# SCSI Bus Phase Control Register

This block is a small CPU-visible control register for a SCSI bus controller. The CPU writes four control bits into it. Three of them name an information-transfer phase through the I/O, C/D and MSG lines, and the fourth asks for the REQ line. When the device works as a target, these bits are driven onto the bus through open-drain style enables. When the device works as an initiator, the outputs stay released.

In initiator mode with DMA enabled, the block watches the incoming bus lines after a synchronizer. Each time REQ goes from inactive to active, it compares the bus phase with the phase held in the register. If the two differ, it latches a phase-mismatch interrupt. The interrupt stays set until the CPU pulses a clear strobe or the block is reset.

Top module: `scsi_phase_ctl`

## Requirements
- R1: A write with `cpu_addr` equal to 3 stores `cpu_wdata[3:0]` in the register. A read at address 3 returns that value on `cpu_rdata[3:0]`, and `cpu_rdata[7:4]` always reads 0. Bit 0 selects I/O, bit 1 selects C/D, bit 2 selects MSG and bit 3 selects REQ.
- R2: Writes to any other address leave the register unchanged. `cpu_rdata` is 0 unless a read at address 3 is in progress.
- R3: While `mode_target` is 1, `drv_io`, `drv_cd`, `drv_msg` and `drv_req` equal register bits 0, 1, 2 and 3. A value of 1 pulls the active-low bus line low, and 0 releases it.
- R4: While `mode_target` is 0, all four drive outputs are 0. This includes the case where register bit 3 (REQ) is set.
- R5: Phase code {I/O,C/D,MSG} has these meanings: 000 is data out, 010 is command, 011 is message out, 100 is data in, 110 is status and 111 is message in. A mismatch interrupt is raised under three conditions together: the mode is initiator with DMA enabled, the two-stage-synchronized REQ makes an inactive-to-active transition, and the synchronized bus code differs from register bits 2:0. A difference in any single bit is enough.
- R6: A REQ edge while the bus code equals register bits 2:0 raises no interrupt.
- R7: No interrupt is raised while `mode_dma` is 0 or `mode_target` is 1.
- R8: Each REQ transition raises the interrupt at most once. After a clear, REQ held active raises nothing, and a later fresh transition raises it again.
- R9: `irq_phase` stays at 1 until `irq_clr` is pulsed, and it reads 0 in the cycle after the clear.
- R10: Reset clears the register, the drive outputs and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 3 | CPU register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| mode_target | input | 1 | 1 = target role, 0 = initiator role |
| mode_dma | input | 1 | DMA mode enable |
| bus_io_n | input | 1 | Bus I/O line, active low |
| bus_cd_n | input | 1 | Bus C/D line, active low |
| bus_msg_n | input | 1 | Bus MSG line, active low |
| bus_req_n | input | 1 | Bus REQ line, active low |
| irq_clr | input | 1 | Clears the mismatch interrupt |
| drv_io | output | 1 | Pull I/O low |
| drv_cd | output | 1 | Pull C/D low |
| drv_msg | output | 1 | Pull MSG low |
| drv_req | output | 1 | Pull REQ low |
| irq_phase | output | 1 | Latched phase-mismatch interrupt |

## Verification
The bench sets the register REQ bit while in initiator mode, which exposes any design that lets REQ leak onto the bus without the target gate. It holds REQ active across a clear, so a level-sensitive detector would fire again immediately. It disables DMA or selects target mode during a mismatching edge, so a design with a missing mode term would raise a spurious interrupt. It also covers a single-bit phase difference (MSG only), an exact match, and a reset in the middle of an interrupt, which catch comparisons on the wrong bits, an inverted comparison, and state that survives reset.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;
    localparam int DATA_W  = 8;
    localparam int CTL_W   = 4;
    localparam int PHASE_W = 3;

    // bit positions inside the control register and the synchronized bus vector
    localparam int BIT_IO  = 0;
    localparam int BIT_CD  = 1;
    localparam int BIT_MSG = 2;
    localparam int BIT_REQ = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_DATA_OUT = 3'b000,
        PH_COMMAND  = 3'b010,
        PH_MSG_OUT  = 3'b011,
        PH_DATA_IN  = 3'b100,
        PH_STATUS   = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             irq;
        logic             req_prev;
    } ctl_state_t;
endpackage

// File: rtl/scsi_phase_sync.sv
module scsi_phase_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_async,
    output logic [W-1:0] out_sync
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stg_d[s] = in_async;
            end else begin : g_next
                assign stg_d[s] = stg_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign out_sync = stg_q[STAGES-1];
endmodule

// File: rtl/scsi_phase_drv.sv
module scsi_phase_drv #(
    parameter int W = 4
) (
    input  logic [W-1:0] ctl,
    input  logic         target,
    output logic [W-1:0] drv
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign drv[b] = ctl[b] & target;
        end
    endgenerate
endmodule

// File: rtl/scsi_phase_chk.sv
module scsi_phase_chk #(
    parameter int PW = 3
) (
    input  logic [PW-1:0] want_phase,
    input  logic [PW-1:0] bus_phase,
    input  logic          req_now,
    input  logic          req_prev,
    input  logic          target,
    input  logic          dma,
    output logic          set_irq
);
    logic req_edge;
    logic differ;

    always_comb begin
        req_edge = req_now & ~req_prev;
        differ   = |(want_phase ^ bus_phase);
        set_irq  = req_edge & differ & dma & ~target;
    end
endmodule

// File: rtl/scsi_phase_ctl.sv
module scsi_phase_ctl
    import scsi_phase_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int REG_ADDR    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              mode_target,
    input  logic              mode_dma,
    input  logic              bus_io_n,
    input  logic              bus_cd_n,
    input  logic              bus_msg_n,
    input  logic              bus_req_n,
    input  logic              irq_clr,
    output logic              drv_io,
    output logic              drv_cd,
    output logic              drv_msg,
    output logic              drv_req,
    output logic              irq_phase
);
    localparam int PAD_W = DATA_W - CTL_W;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    ctl_state_t       st_d, st_q;
    logic [CTL_W-1:0] bus_act;
    logic [CTL_W-1:0] bus_s;
    logic [CTL_W-1:0] drv_vec;
    logic             set_irq;
    logic             wr_hit, rd_hit;

    // active-high view of the bus lines; reset value 0 means released
    assign bus_act = ~{bus_req_n, bus_msg_n, bus_cd_n, bus_io_n};

    scsi_phase_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_async (bus_act),
        .out_sync (bus_s)
    );

    scsi_phase_chk #(.PW(PHASE_W)) u_chk (
        .want_phase (st_q.ctl[PHASE_W-1:0]),
        .bus_phase  (bus_s[PHASE_W-1:0]),
        .req_now    (bus_s[BIT_REQ]),
        .req_prev   (st_q.req_prev),
        .target     (mode_target),
        .dma        (mode_dma),
        .set_irq    (set_irq)
    );

    scsi_phase_drv #(.W(CTL_W)) u_drv (
        .ctl    (st_q.ctl),
        .target (mode_target),
        .drv    (drv_vec)
    );

    assign wr_hit = cpu_wr && (cpu_addr == HIT_ADDR);
    assign rd_hit = cpu_rd && (cpu_addr == HIT_ADDR);

    always_comb begin
        st_d          = st_q;
        st_d.req_prev = bus_s[BIT_REQ];
        if (wr_hit) st_d.ctl = cpu_wdata[CTL_W-1:0];
        if (irq_clr) st_d.irq = 1'b0;
        if (set_irq) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata = rd_hit ? {{PAD_W{1'b0}}, st_q.ctl} : '0;
    assign drv_io    = drv_vec[BIT_IO];
    assign drv_cd    = drv_vec[BIT_CD];
    assign drv_msg   = drv_vec[BIT_MSG];
    assign drv_req   = drv_vec[BIT_REQ];
    assign irq_phase = st_q.irq;
endmodule

// File: rtl/scsi_phase_ctl_sva.sv
module scsi_phase_ctl_sva #(
    parameter int ADDR_W   = 3,
    parameter int REG_ADDR = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic              mode_target,
    input logic              mode_dma,
    input logic              irq_clr,
    input logic              drv_io,
    input logic              drv_cd,
    input logic              drv_msg,
    input logic              drv_req,
    input logic              irq_phase,
    input logic [3:0]        ctl_q
);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[7:4] == 4'h0);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_W'(REG_ADDR)) |=> ctl_q == $past(cpu_wdata[3:0]));

    a_r2_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_addr == ADDR_W'(REG_ADDR)) |-> cpu_rdata == 8'h00);

    a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_target |-> !(drv_io || drv_cd || drv_msg || drv_req));

    a_r7_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_phase) |-> $past(mode_dma && !mode_target));

    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_phase && !irq_clr) |=> irq_phase);
endmodule

bind scsi_phase_ctl scsi_phase_ctl_sva #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .mode_target (mode_target),
    .mode_dma    (mode_dma),
    .irq_clr     (irq_clr),
    .drv_io      (drv_io),
    .drv_cd      (drv_cd),
    .drv_msg     (drv_msg),
    .drv_req     (drv_req),
    .irq_phase   (irq_phase),
    .ctl_q       (st_q.ctl)
);

// File: tb/scsi_phase_ctl_tb.sv
module scsi_phase_ctl_tb;
    import scsi_phase_pkg::*;

    localparam int K_RDATA = 0;
    localparam int K_DRV   = 1;
    localparam int K_IRQ   = 2;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       mode_target = 1'b0, mode_dma = 1'b0;
    logic       bus_io_n = 1'b1, bus_cd_n = 1'b1, bus_msg_n = 1'b1, bus_req_n = 1'b1;
    logic       irq_clr = 1'b0;
    logic       drv_io, drv_cd, drv_msg, drv_req, irq_phase;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    scsi_phase_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mode_target(mode_target),
        .mode_dma(mode_dma), .bus_io_n(bus_io_n), .bus_cd_n(bus_cd_n),
        .bus_msg_n(bus_msg_n), .bus_req_n(bus_req_n), .irq_clr(irq_clr),
        .drv_io(drv_io), .drv_cd(drv_cd), .drv_msg(drv_msg), .drv_req(drv_req),
        .irq_phase(irq_phase)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = cpu_rdata;
                    K_DRV:   act = {4'h0, drv_req, drv_msg, drv_cd, drv_io};
                    default: act = {7'h0, irq_phase};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(int kind, logic [7:0] exp, string tag);
        item_t it;
        @(posedge clk);
        #2;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic cpu_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read_check(logic [2:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        expect_val(K_RDATA, exp, tag);
        cpu_rd = 1'b0;
    endtask

    task automatic set_phase(phase_e p);
        @(negedge clk);
        bus_io_n  = ~p[2];
        bus_cd_n  = ~p[1];
        bus_msg_n = ~p[0];
        repeat (4) @(negedge clk);
    endtask

    task automatic set_req(logic active);
        @(negedge clk);
        bus_req_n = ~active;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // register value {MSG,C/D,I/O} from a phase code {I/O,C/D,MSG}
    function automatic logic [7:0] ph_reg(phase_e p);
        return {5'b0, p[0], p[1], p[2]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        cpu_read_check(3'd3, 8'h00, "R10 reg after reset");
        expect_val(K_DRV, 8'h00, "R10 drv after reset");
        expect_val(K_IRQ, 8'h00, "R10 irq after reset");

        // R1 / R3 target mode
        mode_target = 1'b1;
        cpu_write(3'd3, 8'hFA);
        cpu_read_check(3'd3, 8'h0A, "R1 readback masks upper bits");
        expect_val(K_DRV, 8'h0A, "R3 drive 1010");
        cpu_write(3'd3, 8'h05);
        expect_val(K_DRV, 8'h05, "R3 drive 0101");

        // R2 other addresses
        cpu_write(3'd2, 8'hFF);
        cpu_read_check(3'd3, 8'h05, "R2 foreign write ignored");
        cpu_read_check(3'd2, 8'h00, "R2 foreign read returns 0");
        expect_val(K_RDATA, 8'h00, "R2 idle rdata");

        // R4 initiator releases all lines, REQ bit included
        cpu_write(3'd3, 8'h0F);
        expect_val(K_DRV, 8'h0F, "R3 drive all");
        mode_target = 1'b0;
        expect_val(K_DRV, 8'h00, "R4 initiator released");

        // R6 matching phase
        mode_dma = 1'b1;
        cpu_write(3'd3, ph_reg(PH_COMMAND));
        set_phase(PH_COMMAND);
        set_req(1'b1);
        expect_val(K_IRQ, 8'h00, "R6 match no irq");
        set_req(1'b0);

        // R5 mismatch
        set_phase(PH_DATA_IN);
        set_req(1'b1);
        expect_val(K_IRQ, 8'h01, "R5 mismatch raises irq");
        repeat (6) @(negedge clk);
        expect_val(K_IRQ, 8'h01, "R9 irq held");

        // R9 clear, R8 no refire while REQ held
        pulse_clr();
        expect_val(K_IRQ, 8'h00, "R9 clear drops irq");
        repeat (6) @(negedge clk);
        expect_val(K_IRQ, 8'h00, "R8 no refire on held REQ");
        set_req(1'b0);
        set_req(1'b1);
        expect_val(K_IRQ, 8'h01, "R8 fresh edge fires");
        pulse_clr();
        set_req(1'b0);

        // R5 single-bit difference on MSG
        cpu_write(3'd3, ph_reg(PH_STATUS));
        set_phase(PH_MSG_IN);
        set_req(1'b1);
        expect_val(K_IRQ, 8'h01, "R5 MSG-only difference");
        pulse_clr();
        set_req(1'b0);

        // R7 DMA off
        mode_dma = 1'b0;
        set_req(1'b1);
        expect_val(K_IRQ, 8'h00, "R7 no irq with DMA off");
        set_req(1'b0);

        // R7 target mode
        mode_dma = 1'b1;
        mode_target = 1'b1;
        set_req(1'b1);
        expect_val(K_IRQ, 8'h00, "R7 no irq in target mode");
        set_req(1'b0);
        mode_target = 1'b0;

        // R10 reset mid-run
        set_req(1'b1);
        expect_val(K_IRQ, 8'h01, "R5 irq before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_val(K_IRQ, 8'h00, "R10 reset clears irq");
        cpu_read_check(3'd3, 8'h00, "R10 reset clears reg");
        set_req(1'b0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule